// File: doc/BRIEF.md
# Split Accumulator Register Write Port

This block is the register-file port that owns two 40-bit accumulators and a small set of plain 16-bit registers, all reached through a 5-bit register index. Each accumulator is kept as three separately addressable words: an 8-bit upper byte (stored and read back as a sign-extended 16-bit word), a 16-bit middle word and a 16-bit lower word. Writes through the index path follow special rules for these words. A separate 40-bit path lets an arithmetic unit load a whole accumulator in one cycle. Both accumulators are always presented as complete 40-bit signed values.

Four register indices, 0x0C to 0x0F, do not select plain storage. Each one selects a 4-entry hardware stack. A write to the index pushes the data. A read with the read strobe pops the stack. A read without the strobe only shows the top entry.

Index map used by this block (low 5 bits of the index): 0x0C..0x0F are stacks 0..3; 0x18/0x19 are the lower words of accumulators 0/1; 0x1A/0x1B are the middle words; 0x1C/0x1D are the upper bytes. Every other index is a plain 16-bit register.

Top module: `acc_regport`

## Requirements
- R1: A write to an upper-byte index (0x1C or 0x1D) keeps only data bits 7:0 and stores them sign-extended, so reading the index back gives bit 7 copied into bits 15:8.
- R2: With `ext40_mode` high, a write to a middle-word index (0x1A or 0x1B) stores the data and also sets the same accumulator's upper word to 0xFFFF when data bit 15 is 1, or to 0x0000 when it is 0. The same write clears that accumulator's lower word to 0x0000.
- R3: With `ext40_mode` low, a middle-word write changes only the middle word. The upper and lower words of that accumulator keep their values.
- R4: `accN_full` equals {upper byte bits 7:0, middle word, lower word}, so bit 39 is the sign of the upper byte.
- R5: A cycle with `full_we` high loads accumulator `full_sel`: lower word from bits 15:0, middle word from bits 31:16, and upper word from bits 39:32 sign-extended to 16 bits.
- R6: When `full_we` and an index write hit the same accumulator in the same cycle, the full write wins and the index write has no effect on that accumulator.
- R7: Indices 0x0C..0x0F are four independent last-in-first-out stacks. A write pushes. A read with `rd_en` returns the top entry on `rdata` and removes it at the clock edge.
- R8: A pop of an empty stack returns 0x0000 and leaves the stack empty.
- R9: A push onto a full stack (4 entries) replaces the top entry and keeps the depth at 4.
- R10: Index bits above bit 4 are ignored on both the read and the write index.
- R11: Reading any index other than a stack returns the stored word combinationally with no side effect. A stack index read without `rd_en` shows the top entry without popping it.
- R12: After reset every register and accumulator word reads 0x0000 and every stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Index write strobe |
| wr_idx | input | IDX_W (8) | Write index; only bits 4:0 are decoded |
| wr_data | input | 16 | Index write data |
| ext40_mode | input | 1 | Enables sign extension of middle-word writes across the accumulator |
| full_we | input | 1 | Whole-accumulator write strobe |
| full_sel | input | 1 | Accumulator chosen by the whole write |
| full_data | input | 40 | Whole-accumulator write value |
| rd_en | input | 1 | Read strobe; pops a stack when a stack index is read |
| rd_idx | input | IDX_W (8) | Read index; only bits 4:0 are decoded |
| rdata | output | 16 | Combinational read data |
| acc0_full | output | 40 | Assembled accumulator 0 |
| acc1_full | output | 40 | Assembled accumulator 1 |

## Verification
A wrong accumulator word shows up on the matching `accN_full` output in the cycle right after the write, and on `rdata` as soon as the word's index is presented, because the read is combinational. A wrong stack depth or pointer is hidden until the stack is popped. The bench therefore drains each stack it fills, past the bottom, so that a pointer error shows as a wrong value or as a non-zero empty pop within a few pops. Missing sign extension or a missing clear of the lower word shows only on the other words, so each special write is followed by reads of the other words of that accumulator.

// File: rtl/acc_regport_pkg.sv
package acc_regport_pkg;
  localparam int DATA_W    = 16;
  localparam int SEL_W     = 5;
  localparam int NUM_REGS  = 1 << SEL_W;
  localparam int NUM_ACC   = 2;
  localparam int NUM_STK   = 4;
  localparam int ACC_W     = 40;
  localparam int TOP_W     = ACC_W - 2 * DATA_W;

  localparam logic [SEL_W-1:0] STK_BASE = 5'h0C;
  localparam logic [SEL_W-1:0] LO_BASE  = 5'h18;
  localparam logic [SEL_W-1:0] MID_BASE = 5'h1A;
  localparam logic [SEL_W-1:0] HI_BASE  = 5'h1C;

  function automatic logic sel_is_stack(logic [SEL_W-1:0] s);
    return (s >= STK_BASE) && (s <= STK_BASE + 5'(NUM_STK - 1));
  endfunction

  function automatic logic sel_is_acc(logic [SEL_W-1:0] s);
    return (s >= LO_BASE) && (s <= HI_BASE + 5'(NUM_ACC - 1));
  endfunction
endpackage

// File: rtl/hw_stack.sv
module hw_stack #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] top_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [PTR_W-1:0]  top_ptr, free_ptr;
  logic              st_en;

  assign top_ptr  = PTR_W'(cnt_q - 1'b1);
  assign free_ptr = PTR_W'(cnt_q);
  assign top_data = (cnt_q == '0) ? '0 : mem_q[top_ptr];
  assign st_en    = push | pop;

  always_comb begin
    cnt_d = cnt_q;
    mem_d = mem_q;
    if (push && pop) begin
      if (cnt_q == '0) begin
        mem_d[0] = push_data;
        cnt_d    = CNT_W'(1);
      end else begin
        mem_d[top_ptr] = push_data;
      end
    end else if (push) begin
      if (cnt_q == FULL_CNT) begin
        mem_d[top_ptr] = push_data;
      end else begin
        mem_d[free_ptr] = push_data;
        cnt_d           = cnt_q + 1'b1;
      end
    end else if (pop && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (st_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (st_en) mem_q <= mem_d;
  end

  // R8: a lone pop on an empty stack leaves it empty
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> (cnt_q == '0 && top_data == '0));

  // R9: a lone push on a full stack keeps the depth and exposes the new value
  p_full_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt_q == FULL_CNT) |=> (cnt_q == FULL_CNT && top_data == $past(push_data)));

  // R7: depth never goes past the capacity
  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
endmodule

// File: rtl/acc_split_store.sv
module acc_split_store #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_mid,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext40_mode,
  input  logic              full_wr,
  input  logic [ACC_W-1:0]  full_data,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] mid_q,
  output logic [DATA_W-1:0] hi_q,
  output logic [ACC_W-1:0]  full_q
);
  localparam int TOP_W = ACC_W - 2 * DATA_W;
  localparam int EXT_W = DATA_W - TOP_W;

  logic [DATA_W-1:0] lo_d, mid_d, hi_d;
  logic              acc_en;

  assign acc_en = full_wr | wr_lo | wr_mid | wr_hi;
  assign full_q = {hi_q[TOP_W-1:0], mid_q, lo_q};

  always_comb begin
    lo_d  = lo_q;
    mid_d = mid_q;
    hi_d  = hi_q;
    if (full_wr) begin
      lo_d  = full_data[DATA_W-1:0];
      mid_d = full_data[2*DATA_W-1:DATA_W];
      hi_d  = {{EXT_W{full_data[ACC_W-1]}}, full_data[ACC_W-1:2*DATA_W]};
    end else begin
      if (wr_lo) lo_d = wr_data;
      if (wr_hi) hi_d = {{EXT_W{wr_data[TOP_W-1]}}, wr_data[TOP_W-1:0]};
      if (wr_mid) begin
        mid_d = wr_data;
        if (ext40_mode) begin
          hi_d = {DATA_W{wr_data[DATA_W-1]}};
          lo_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      mid_q <= '0;
      hi_q  <= '0;
    end else if (acc_en) begin
      lo_q  <= lo_d;
      mid_q <= mid_d;
      hi_q  <= hi_d;
    end
  end

  p_hi_trunc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !full_wr) |=>
      (hi_q == {{EXT_W{$past(wr_data[TOP_W-1])}}, $past(wr_data[TOP_W-1:0])}));

  p_mid_extend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mid && ext40_mode && !full_wr) |=>
      (lo_q == '0 && hi_q == {DATA_W{$past(wr_data[DATA_W-1])}}));

  p_mid_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mid && !ext40_mode && !full_wr && !wr_lo && !wr_hi) |=>
      ($stable(lo_q) && $stable(hi_q)));

  p_full_split_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_wr |=> (full_q == $past(full_data) && hi_q[DATA_W-1] == hi_q[TOP_W-1]));
endmodule

// File: rtl/acc_regport.sv
module acc_regport
  import acc_regport_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int STK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ext40_mode,
  input  logic              full_we,
  input  logic              full_sel,
  input  logic [ACC_W-1:0]  full_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rdata,
  output logic [ACC_W-1:0]  acc0_full,
  output logic [ACC_W-1:0]  acc1_full
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [SEL_W-1:0]  wsel, rsel;
  logic [DATA_W-1:0] plain_q [NUM_REGS];
  logic              plain_en;
  logic [DATA_W-1:0] stk_top [NUM_STK];
  logic [DATA_W-1:0] acc_lo  [NUM_ACC];
  logic [DATA_W-1:0] acc_mid [NUM_ACC];
  logic [DATA_W-1:0] acc_hi  [NUM_ACC];
  logic [ACC_W-1:0]  acc_full [NUM_ACC];
  logic              unused_idx_hi;

  assign wsel          = wr_idx[SEL_W-1:0];
  assign rsel          = rd_idx[SEL_W-1:0];
  assign unused_idx_hi = ^{wr_idx[IDX_W-1:SEL_W], rd_idx[IDX_W-1:SEL_W]};

  // Reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Plain registers
  assign plain_en = wr_en && !sel_is_stack(wsel) && !sel_is_acc(wsel);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int i = 0; i < NUM_REGS; i++) plain_q[i] <= '0;
    end else if (plain_en) begin
      plain_q[wsel] <= wr_data;
    end
  end

  // Stacks
  for (genvar s = 0; s < NUM_STK; s++) begin : g_stk
    logic push, pop;
    assign push = wr_en && (wsel == STK_BASE + 5'(s));
    assign pop  = rd_en && (rsel == STK_BASE + 5'(s));
    hw_stack #(.DATA_W(DATA_W), .DEPTH(STK_DEPTH)) u_stk (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .push      (push),
      .pop       (pop),
      .push_data (wr_data),
      .top_data  (stk_top[s])
    );
  end

  // Accumulators
  for (genvar a = 0; a < NUM_ACC; a++) begin : g_acc
    logic wlo, wmid, whi, fwr;
    assign wlo  = wr_en && (wsel == LO_BASE  + 5'(a));
    assign wmid = wr_en && (wsel == MID_BASE + 5'(a));
    assign whi  = wr_en && (wsel == HI_BASE  + 5'(a));
    assign fwr  = full_we && (full_sel == 1'(a));
    acc_split_store #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .wr_lo      (wlo),
      .wr_mid     (wmid),
      .wr_hi      (whi),
      .wr_data    (wr_data),
      .ext40_mode (ext40_mode),
      .full_wr    (fwr),
      .full_data  (full_data),
      .lo_q       (acc_lo[a]),
      .mid_q      (acc_mid[a]),
      .hi_q       (acc_hi[a]),
      .full_q     (acc_full[a])
    );
  end

  assign acc0_full = acc_full[0];
  assign acc1_full = acc_full[1];

  // Combinational read
  always_comb begin
    rdata = plain_q[rsel];
    if (sel_is_stack(rsel)) rdata = stk_top[rsel[1:0]];
    for (int a = 0; a < NUM_ACC; a++) begin
      if (rsel == LO_BASE  + 5'(a)) rdata = acc_lo[a];
      if (rsel == MID_BASE + 5'(a)) rdata = acc_mid[a];
      if (rsel == HI_BASE  + 5'(a)) rdata = acc_hi[a];
    end
  end

  // R6: a whole write beats an index write to the same accumulator
  p_full_wins_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (full_we && !full_sel) |=> (acc0_full == $past(full_data)));

  // R11: plain registers only change on a plain write
  p_plain_hold_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !plain_en |=> $stable(plain_q[3]));
endmodule

// File: tb/acc_regport_tb.sv
module acc_regport_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, ext40_mode, full_we, full_sel, rd_en;
  logic [7:0]  wr_idx, rd_idx;
  logic [15:0] wr_data;
  logic [39:0] full_data;
  logic [15:0] rdata;
  logic [39:0] acc0_full, acc1_full;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_regport u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ext40_mode(ext40_mode), .full_we(full_we), .full_sel(full_sel),
    .full_data(full_data), .rd_en(rd_en), .rd_idx(rd_idx), .rdata(rdata),
    .acc0_full(acc0_full), .acc1_full(acc1_full)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [7:0]  widx;
    logic [15:0] wd;
    logic        mode;
    logic [7:0]  ridx;
    logic [15:0] exp;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{4'd1,  8'h1C, 16'h12F0, 1'b0, 8'h1C, 16'hFFF0}, // R1 negative byte
    '{4'd1,  8'h1D, 16'hAB7F, 1'b0, 8'h1D, 16'h007F}, // R1 positive byte
    '{4'd11, 8'h18, 16'h1234, 1'b0, 8'h18, 16'h1234}, // R11 lower word
    '{4'd3,  8'h1A, 16'h8001, 1'b0, 8'h1C, 16'hFFF0}, // R3 upper kept
    '{4'd3,  8'h03, 16'hBEEF, 1'b0, 8'h18, 16'h1234}, // R3 lower kept
    '{4'd11, 8'h05, 16'h5555, 1'b0, 8'h03, 16'hBEEF}, // R11 plain reg
    '{4'd2,  8'h1A, 16'h8001, 1'b1, 8'h1C, 16'hFFFF}, // R2 upper all ones
    '{4'd2,  8'h1F, 16'hA5A5, 1'b0, 8'h18, 16'h0000}, // R2 lower cleared
    '{4'd2,  8'h1B, 16'h7000, 1'b1, 8'h1D, 16'h0000}, // R2 upper all zeros
    '{4'd10, 8'hE3, 16'h4242, 1'b0, 8'h03, 16'h4242}, // R10 write upper bits
    '{4'd10, 8'h06, 16'h0001, 1'b0, 8'h23, 16'h4242}  // R10 read upper bits
  };

  task automatic check(input logic [39:0] act, input logic [39:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] idx, input logic [15:0] d, input logic m);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d; ext40_mode = m;
    @(negedge clk);
    wr_en = 1'b0; ext40_mode = 1'b0;
  endtask

  task automatic peek(input logic [7:0] idx, input logic [15:0] exp, input string tag);
    rd_idx = idx; rd_en = 1'b0;
    #1;
    check({24'h0, rdata}, {24'h0, exp}, tag);
  endtask

  task automatic pop(input logic [7:0] idx, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rd_idx = idx; rd_en = 1'b1;
    #1;
    check({24'h0, rdata}, {24'h0, exp}, tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wr_en = 0; wr_idx = 0; wr_data = 0; ext40_mode = 0;
    full_we = 0; full_sel = 0; full_data = 0; rd_en = 0; rd_idx = 0;
    do_reset();

    // R12: reset state
    peek(8'h03, 16'h0000, "R12 plain");
    check(acc0_full, 40'h0, "R12 acc0");
    check(acc1_full, 40'h0, "R12 acc1");
    pop(8'h0C, 16'h0000, "R12 stack empty");

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      do_wr(VECS[i].widx, VECS[i].wd, VECS[i].mode);
      peek(VECS[i].ridx, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R4: assembly
    check(acc0_full, 40'hFF_8001_0000, "R4 acc0");
    do_wr(8'h19, 16'h0BCD, 1'b0);
    check(acc1_full, 40'h00_7000_0BCD, "R4 acc1");

    // R5: whole write
    @(negedge clk);
    full_we = 1'b1; full_sel = 1'b0; full_data = 40'h80_1234_5678;
    @(negedge clk);
    full_we = 1'b0;
    peek(8'h1C, 16'hFF80, "R5 upper");
    peek(8'h1A, 16'h1234, "R5 middle");
    peek(8'h18, 16'h5678, "R5 lower");
    check(acc0_full, 40'h80_1234_5678, "R5 full");

    // R6: whole write beats index write in the same cycle
    @(negedge clk);
    full_we = 1'b1; full_sel = 1'b1; full_data = 40'h01_2222_3333;
    wr_en = 1'b1; wr_idx = 8'h19; wr_data = 16'hFFFF;
    @(negedge clk);
    full_we = 1'b0; wr_en = 1'b0;
    peek(8'h19, 16'h3333, "R6 lower");
    check(acc1_full, 40'h01_2222_3333, "R6 full");

    // R7: independent LIFO stacks
    do_wr(8'h0C, 16'h0111, 1'b0);
    do_wr(8'h0C, 16'h0222, 1'b0);
    do_wr(8'h0D, 16'h0999, 1'b0);
    pop(8'h0C, 16'h0222, "R7 pop1");
    pop(8'h0C, 16'h0111, "R7 pop2");
    pop(8'h0D, 16'h0999, "R7 other stack");

    // R11: stack read without strobe does not pop
    do_wr(8'h0E, 16'h0777, 1'b0);
    peek(8'h0E, 16'h0777, "R11 peek1");
    @(negedge clk);
    peek(8'h0E, 16'h0777, "R11 peek2");
    pop(8'h0E, 16'h0777, "R11 pop");

    // R8: empty pops
    pop(8'h0E, 16'h0000, "R8 empty1");
    pop(8'h0E, 16'h0000, "R8 empty2");
    do_wr(8'h0E, 16'h0042, 1'b0);
    pop(8'h0E, 16'h0042, "R8 after empty");
    pop(8'h0E, 16'h0000, "R8 drained");

    // R9: overflow replaces top
    for (int k = 1; k <= 5; k++) do_wr(8'h0F, 16'(k), 1'b0);
    pop(8'h0F, 16'h0005, "R9 top replaced");
    pop(8'h0F, 16'h0003, "R9 next");
    pop(8'h0F, 16'h0002, "R9 next2");
    pop(8'h0F, 16'h0001, "R9 bottom");
    pop(8'h0F, 16'h0000, "R9 empty");

    // R12: reset mid-run
    do_wr(8'h0C, 16'h0AAA, 1'b0);
    do_reset();
    check(acc0_full, 40'h0, "R12 acc0 again");
    peek(8'h03, 16'h0000, "R12 plain again");
    pop(8'h0C, 16'h0000, "R12 stack cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule